// File: doc/BRIEF.md
# SPI Flash Program Sequencer

This block carries out complete serial-flash operations on behalf of a simple requester. It sits above a byte-level SPI shifter that is assumed to exist beside it. A single start strobe with a 3-bit operation code, a 24-bit address and a byte count launches one of six operations:

- wake the flash from deep power-down;
- erase a 64 KB sector;
- program part of one page;
- read bytes back;
- clear the write protection;
- put the flash to sleep.

The sequencer owns the flash chip select and the active-low reset of the FPGA that shares the flash. It holds that FPGA in reset for the whole of each flash access. It splits every operation into frames: chip select low, a few bytes, chip select high. It also polls the flash status register until the part reports idle.

Program data is pulled one byte at a time. The requester keeps the next byte on `wr_data` and advances it after each `wr_req` pulse. Read data leaves on `rd_data` with a one-cycle `rd_valid` strobe. Each operation ends with a one-cycle `done` pulse. After that pulse, `err` and `err_code` describe the result until the next start.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, and while no operation has run, `flash_cs_n` and `fpga_rst_n` are both 1 and `busy`, `done` and `err` are 0. Asserting reset in the middle of an operation returns the block to this state.
- R2: `flash_cs_n` is 0 only in cycles where `fpga_rst_n` is 0. Every accepted operation except sleep ends with `flash_cs_n`=1 and `fpga_rst_n`=0.
- R3: Wake (op 0) sends three frames in order:
  - a frame of 8 clocks with MOSI high (`xfer_bits`=8, byte 0xFF);
  - a frame of 2 clocks with MOSI high (`xfer_bits`=2, byte 0xFF);
  - a one-byte frame holding the release-from-power-down opcode, 0xAB by default.
- R4: Erase (op 1), program (op 2) and read (op 3) frames carry the opcode followed by three address bytes, most significant byte first. The default opcodes are 0xD8, 0x02 and 0x03. `xfer_start` is only raised while `flash_cs_n` is 0.
- R5: Erase and program are preceded by a separate one-byte write-enable frame, 0x06 by default.
- R6: After a write (erase, program, status write), the block repeats a two-byte frame: the read-status opcode (0x05) and a dummy byte. It stops once bit 0 of the second returned byte is 0.
- R7: If `poll_max` consecutive polls all return bit 0 = 1, the operation ends with `err`=1 and `err_code`=2. No further poll frame is sent.
- R8: Program sends `op_len` data bytes taken from `wr_data`, one `wr_req` pulse per byte. Read returns `op_len` bytes, each marked by one `rd_valid` pulse.
- R9: A request is rejected, with `err`=1, `err_code`=1, a `done` pulse, no chip select activity and `busy` staying 0, in any of these cases:
  - op codes 6 or 7;
  - a program whose length is 0, greater than 256, or whose low address byte plus length exceeds 256;
  - a read whose length is 0 or greater than 256.
- R10: Unprotect (op 4) runs this sequence:
  - a write-enable frame;
  - a write-status frame (0x01, then 0x00);
  - polling until idle;
  - a read-status frame.
  If the byte read back is non-zero, the operation ends with `err_code`=3.
- R11: Sleep (op 5) sends the power-down opcode (0xB9 by default), then leaves both `flash_cs_n` and `fpga_rst_n` at 1.
- R12: `done` is high for exactly one cycle, in the first cycle where `busy` is 0. `err` and `err_code` keep their values until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | One-cycle start strobe, taken only when not busy |
| op_code | input | 3 | 0 wake, 1 erase, 2 program, 3 read, 4 unprotect, 5 sleep |
| op_addr | input | 24 | Flash byte address |
| op_len | input | 9 | Byte count for program and read |
| poll_max | input | 16 | Number of busy status polls allowed before timeout |
| wr_data | input | 8 | Next program byte, advanced after each wr_req |
| wr_req | output | 1 | Program byte consumed this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data valid strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Last operation failed |
| err_code | output | 2 | 0 none, 1 bad request, 2 poll timeout, 3 protect readback non-zero |
| flash_cs_n | output | 1 | Flash chip select, active low |
| fpga_rst_n | output | 1 | FPGA reset, active low |
| xfer_start | output | 1 | Starts one shifter transfer |
| xfer_tx | output | 8 | Byte to shift out, MSB first |
| xfer_bits | output | 4 | Number of clocks in this transfer (1 to 8) |
| xfer_done | input | 1 | Shifter finished the transfer |
| xfer_rx | input | 8 | Byte shifted in, valid with xfer_done |

## Verification
The conditions hardest to reach from the ports are the status-dependent branches: a flash that stays busy past the poll budget, and a protect readback that will not clear. Both depend on what the flash answers, not on what the requester asks. The bench therefore puts a byte-level flash model behind its shifter model. Before each operation, the model is loaded with a number of busy answers to give. A separate knob makes chosen status bits stick at 1. Together these steer the sequencer into the repeat, timeout and protect-fail paths, and into the exact poll counts that the frame totals are checked against.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam logic [2:0] OP_WAKE   = 3'd0;
  localparam logic [2:0] OP_ERASE  = 3'd1;
  localparam logic [2:0] OP_PROG   = 3'd2;
  localparam logic [2:0] OP_READ   = 3'd3;
  localparam logic [2:0] OP_UNPROT = 3'd4;
  localparam logic [2:0] OP_SLEEP  = 3'd5;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_REQ     = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT = 2'd2;
  localparam logic [1:0] ERR_PROTECT = 2'd3;

  typedef enum logic [3:0] {
    FR_END, FR_RST_LONG, FR_RST_SHORT, FR_WAKE, FR_WREN, FR_ERASE,
    FR_PROG, FR_READ, FR_WRSR, FR_POLL, FR_CHECK, FR_SLEEP
  } frame_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_SEL, ST_SHIFT, ST_WAIT, ST_DESEL, ST_DONE
  } state_e;

  typedef struct packed {
    logic [7:0] wren;
    logic [7:0] erase;
    logic [7:0] prog;
    logic [7:0] read;
    logic [7:0] rdsr;
    logic [7:0] wrsr;
    logic [7:0] wake;
    logic [7:0] sleep;
  } opcodes_t;

  localparam opcodes_t OPC_DEFAULT = '{
    wren: 8'h06, erase: 8'hD8, prog: 8'h02, read: 8'h03,
    rdsr: 8'h05, wrsr: 8'h01, wake: 8'hAB, sleep: 8'hB9
  };

  // Frame to issue at a given step of an operation; FR_END closes it.
  function automatic frame_e frame_at(logic [2:0] op, logic [2:0] step);
    frame_e k;
    k = FR_END;
    case (op)
      OP_WAKE: case (step)
        3'd0: k = FR_RST_LONG;
        3'd1: k = FR_RST_SHORT;
        3'd2: k = FR_WAKE;
        default: k = FR_END;
      endcase
      OP_ERASE: case (step)
        3'd0: k = FR_WREN;
        3'd1: k = FR_ERASE;
        3'd2: k = FR_POLL;
        default: k = FR_END;
      endcase
      OP_PROG: case (step)
        3'd0: k = FR_WREN;
        3'd1: k = FR_PROG;
        3'd2: k = FR_POLL;
        default: k = FR_END;
      endcase
      OP_READ: k = (step == 3'd0) ? FR_READ : FR_END;
      OP_UNPROT: case (step)
        3'd0: k = FR_WREN;
        3'd1: k = FR_WRSR;
        3'd2: k = FR_POLL;
        3'd3: k = FR_CHECK;
        default: k = FR_END;
      endcase
      OP_SLEEP: k = (step == 3'd0) ? FR_SLEEP : FR_END;
      default: k = FR_END;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/fps_page_check.sv
module fps_page_check import fps_pkg::*; #(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = 24,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int LEN_W     = OFF_W + 1
) (
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              ok
);

  function automatic logic len_ok(logic [LEN_W-1:0] n);
    return (n != '0) && (n <= LEN_W'(PAGE_BYTES));
  endfunction

  // Page fit: start offset plus length may reach, never pass, the page end.
  function automatic logic page_fits(logic [OFF_W-1:0] off, logic [LEN_W-1:0] n);
    logic [LEN_W:0] end_pos;
    end_pos = {2'b00, off} + {1'b0, n};
    return len_ok(n) && (end_pos <= (LEN_W+1)'(PAGE_BYTES));
  endfunction

  always_comb begin
    case (op)
      OP_PROG:                                   ok = page_fits(addr[OFF_W-1:0], len);
      OP_READ:                                   ok = len_ok(len);
      OP_WAKE, OP_ERASE, OP_UNPROT, OP_SLEEP:    ok = 1'b1;
      default:                                   ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/fps_frame_gen.sv
module fps_frame_gen import fps_pkg::*; #(
  parameter opcodes_t OPC = OPC_DEFAULT,
  parameter int LEN_W     = 9,
  parameter int ADDR_W    = 24,
  localparam int IDX_W    = LEN_W + 1
) (
  input  frame_e            kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [7:0]        wdata,
  output logic [7:0]        tx,
  output logic [3:0]        bits,
  output logic              last,
  output logic              data_out,
  output logic              data_in,
  output logic              sr_byte
);

  function automatic logic [IDX_W-1:0] frame_len(frame_e k, logic [LEN_W-1:0] n);
    case (k)
      FR_PROG, FR_READ:          return IDX_W'(n) + IDX_W'(4);
      FR_ERASE:                  return IDX_W'(4);
      FR_WRSR, FR_POLL, FR_CHECK: return IDX_W'(2);
      default:                   return IDX_W'(1);
    endcase
  endfunction

  function automatic logic [7:0] opcode_of(frame_e k);
    case (k)
      FR_WREN:          return OPC.wren;
      FR_ERASE:         return OPC.erase;
      FR_PROG:          return OPC.prog;
      FR_READ:          return OPC.read;
      FR_WRSR:          return OPC.wrsr;
      FR_POLL, FR_CHECK: return OPC.rdsr;
      FR_WAKE:          return OPC.wake;
      FR_SLEEP:         return OPC.sleep;
      default:          return 8'hFF;
    endcase
  endfunction

  logic has_addr;
  assign has_addr = (kind == FR_ERASE) || (kind == FR_PROG) || (kind == FR_READ);
  assign data_out = (kind == FR_PROG) && (idx >= IDX_W'(4));
  assign data_in  = (kind == FR_READ) && (idx >= IDX_W'(4));
  assign sr_byte  = ((kind == FR_POLL) || (kind == FR_CHECK)) && (idx == IDX_W'(1));
  assign last     = (idx == frame_len(kind, len) - IDX_W'(1));
  assign bits     = (kind == FR_RST_SHORT) ? 4'd2 : 4'd8;

  always_comb begin
    tx = 8'h00;
    if (idx == '0)                         tx = opcode_of(kind);
    else if (has_addr && idx == IDX_W'(1)) tx = addr[23:16];
    else if (has_addr && idx == IDX_W'(2)) tx = addr[15:8];
    else if (has_addr && idx == IDX_W'(3)) tx = addr[7:0];
    else if (data_out)                     tx = wdata;
  end

endmodule

// File: rtl/fps_poll_ctr.sv
module fps_poll_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] count_q;

  // Expired when the busy poll being judged is the limit-th one.
  assign expired = ({1'b0, count_q} + (CW+1)'(1)) >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else if (inc) count_q <= count_q + CW'(1);
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq import fps_pkg::*; #(
  parameter opcodes_t OPC  = OPC_DEFAULT,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_W     = 16,
  localparam int LEN_W     = $clog2(PAGE_BYTES) + 1,
  localparam int ADDR_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [LEN_W-1:0]  op_len,
  input  logic [POLL_W-1:0] poll_max,
  input  logic [7:0]        wr_data,
  output logic              wr_req,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              flash_cs_n,
  output logic              fpga_rst_n,
  output logic              xfer_start,
  output logic [7:0]        xfer_tx,
  output logic [3:0]        xfer_bits,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx
);

  localparam int IDX_W = LEN_W + 1;

  state_e            state_q;
  frame_e            kind_q;
  logic [2:0]        op_q, step_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        sr_q, rd_data_q;
  logic              rstn_q, done_q, err_q, rd_valid_q;
  logic [1:0]        ecode_q;

  // Named internal events (also observed by the checker)
  logic   req_ok, idle_w, op_is_sleep, poll_busy, check_bad, poll_expired;
  logic   poll_clr, poll_inc;
  frame_e first_kind, next_kind;
  logic   g_last, g_data_out, g_data_in, g_sr_byte;

  assign idle_w      = (state_q == ST_IDLE);
  assign op_is_sleep = (op_q == OP_SLEEP);
  assign first_kind  = frame_at(op_code, 3'd0);
  assign next_kind   = frame_at(op_q, step_q + 3'd1);
  assign poll_busy   = (state_q == ST_DESEL) && (kind_q == FR_POLL) && sr_q[0];
  assign check_bad   = (state_q == ST_DESEL) && (kind_q == FR_CHECK) && (sr_q != 8'h00);
  assign poll_clr    = idle_w && op_start;
  assign poll_inc    = poll_busy && !poll_expired;

  fps_page_check #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_check (
    .op(op_code), .addr(op_addr), .len(op_len), .ok(req_ok)
  );

  fps_frame_gen #(.OPC(OPC), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_gen (
    .kind(kind_q), .idx(idx_q), .addr(addr_q), .len(len_q), .wdata(wr_data),
    .tx(xfer_tx), .bits(xfer_bits), .last(g_last), .data_out(g_data_out),
    .data_in(g_data_in), .sr_byte(g_sr_byte)
  );

  fps_poll_ctr #(.CW(POLL_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc),
    .limit(poll_max), .expired(poll_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      kind_q     <= FR_END;
      op_q       <= OP_WAKE;
      step_q     <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      sr_q       <= '0;
      rd_data_q  <= '0;
      rstn_q     <= 1'b1;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      ecode_q    <= ERR_NONE;
      rd_valid_q <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (op_start) begin
          err_q   <= 1'b0;
          ecode_q <= ERR_NONE;
          if (!req_ok) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            ecode_q <= ERR_REQ;
          end else begin
            op_q    <= op_code;
            addr_q  <= op_addr;
            len_q   <= op_len;
            step_q  <= '0;
            kind_q  <= first_kind;
            idx_q   <= '0;
            rstn_q  <= 1'b0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP:   state_q <= ST_SEL;
        ST_SEL:   state_q <= ST_SHIFT;
        ST_SHIFT: state_q <= ST_WAIT;
        ST_WAIT: if (xfer_done) begin
          if (g_data_in) begin
            rd_data_q  <= xfer_rx;
            rd_valid_q <= 1'b1;
          end
          if (g_sr_byte) sr_q <= xfer_rx;
          if (g_last) state_q <= ST_DESEL;
          else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_SHIFT;
          end
        end
        ST_DESEL: begin
          idx_q <= '0;
          if (poll_busy) begin
            if (poll_expired) begin
              err_q   <= 1'b1;
              ecode_q <= ERR_TIMEOUT;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_GAP;
            end
          end else if (check_bad) begin
            err_q   <= 1'b1;
            ecode_q <= ERR_PROTECT;
            state_q <= ST_DONE;
          end else if (next_kind == FR_END) begin
            state_q <= ST_DONE;
          end else begin
            step_q  <= step_q + 3'd1;
            kind_q  <= next_kind;
            state_q <= ST_GAP;
          end
        end
        ST_DONE: begin
          done_q <= 1'b1;
          if (op_is_sleep && !err_q) rstn_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign flash_cs_n = !((state_q == ST_SEL) || (state_q == ST_SHIFT) || (state_q == ST_WAIT));
  assign fpga_rst_n = rstn_q;
  assign xfer_start = (state_q == ST_SHIFT);
  assign wr_req     = xfer_start && g_data_out;
  assign busy       = !idle_w;
  assign done       = done_q;
  assign err        = err_q;
  assign err_code   = ecode_q;
  assign rd_data    = rd_data_q;
  assign rd_valid   = rd_valid_q;

endmodule

// File: rtl/fps_checker.sv
module fps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       fpga_rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       xfer_start,
  input logic       wr_req,
  input logic       op_start,
  input logic       req_ok,
  input logic       idle,
  input logic       op_is_sleep
);

  assert_cs_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !fpga_rst_n);

  assert_xfer_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !cs_n);

  assert_pull_with_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> xfer_start);

  assert_reject_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && op_start && !req_ok) |=> (done && err && err_code == 2'd1 && !busy && cs_n));

  assert_sleep_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && op_is_sleep) |-> (cs_n && fpga_rst_n));

  assert_done_on_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind flash_prog_seq fps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(flash_cs_n), .fpga_rst_n(fpga_rst_n),
  .busy(busy), .done(done), .err(err), .err_code(err_code),
  .xfer_start(xfer_start), .wr_req(wr_req), .op_start(op_start),
  .req_ok(req_ok), .idle(idle_w), .op_is_sleep(op_is_sleep)
);

// File: tb/flash_prog_seq_tb.sv
`timescale 1ns/1ps
module flash_prog_seq_tb;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        op_start = 1'b0;
  logic [2:0]  op_code = '0;
  logic [23:0] op_addr = '0;
  logic [8:0]  op_len = '0;
  logic [15:0] poll_max = 16'd16;
  logic [7:0]  wr_data;
  logic        wr_req, rd_valid, busy, done, err, flash_cs_n, fpga_rst_n, xfer_start;
  logic [7:0]  rd_data, xfer_tx;
  logic [1:0]  err_code;
  logic [3:0]  xfer_bits;
  logic        xfer_done = 1'b0;
  logic [7:0]  xfer_rx = '0;

  flash_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .op_addr(op_addr), .op_len(op_len), .poll_max(poll_max), .wr_data(wr_data),
    .wr_req(wr_req), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .done(done), .err(err), .err_code(err_code), .flash_cs_n(flash_cs_n),
    .fpga_rst_n(fpga_rst_n), .xfer_start(xfer_start), .xfer_tx(xfer_tx),
    .xfer_bits(xfer_bits), .xfer_done(xfer_done), .xfer_rx(xfer_rx)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // Flash and shifter model state
  logic [7:0] mem [0:1023];
  logic [7:0] op_log [0:63];
  logic [3:0] bits_log [0:63];
  logic [7:0] abuf [0:2];
  logic [7:0] rd_buf [0:511];
  logic [7:0] cur_op = '0, sr_nv = '0, stuck = '0;
  int fidx = 0, fcnt = 0, lat = 0, busy_left = 0, wcnt = 0, rcnt = 0;
  int cs_viol = 0, spi_viol = 0, fa = 0;

  assign wr_data = 8'hA0 ^ wcnt[7:0];

  always @(posedge clk) begin
    logic [7:0] rx;
    xfer_done <= 1'b0;
    if (lat != 0) begin
      lat--;
      if (lat == 0) xfer_done <= 1'b1;
    end
    if (rst_n && !flash_cs_n && fpga_rst_n) cs_viol++;
    if (flash_cs_n) fidx = 0;
    if (xfer_start) begin
      if (flash_cs_n) spi_viol++;
      rx = 8'hFF;
      if (fidx == 0) begin
        cur_op = xfer_tx;
        if (fcnt < 64) begin
          op_log[fcnt] = xfer_tx;
          bits_log[fcnt] = xfer_bits;
        end
        fcnt++;
      end else begin
        if ((cur_op == 8'hD8 || cur_op == 8'h02 || cur_op == 8'h03) && fidx <= 3) begin
          abuf[fidx-1] = xfer_tx;
          if (fidx == 1) fa = 0;
          fa = (fa << 8) | int'(xfer_tx);
        end
        case (cur_op)
          8'h05: if (fidx == 1) begin
            rx = {sr_nv[7:1], busy_left != 0};
            if (busy_left > 0) busy_left--;
          end
          8'h03: if (fidx >= 4) rx = mem[(fa + fidx - 4) & 1023];
          8'h02: if (fidx >= 4) mem[(fa + fidx - 4) & 1023] = xfer_tx;
          8'h01: if (fidx == 1) sr_nv = xfer_tx | stuck;
          default: ;
        endcase
      end
      xfer_rx <= rx;
      lat = 2;
      fidx++;
    end
    if (wr_req) wcnt++;
    if (rd_valid) begin
      if (rcnt < 512) rd_buf[rcnt] = rd_data;
      rcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [23:0] addr;
    logic [8:0]  len;
    logic [15:0] pmax;
    logic [7:0]  busy_n;
    logic [1:0]  ecode;
    logic [7:0]  frames;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 24'h000000, 9'd0,   16'd16, 8'd0,   2'd0, 8'd3},   // wake
    '{3'd1, 24'h012345, 9'd0,   16'd16, 8'd3,   2'd0, 8'd6},   // erase, 3 busy polls
    '{3'd2, 24'h000010, 9'd16,  16'd16, 8'd2,   2'd0, 8'd5},   // program 16
    '{3'd3, 24'h000010, 9'd16,  16'd16, 8'd0,   2'd0, 8'd1},   // read back
    '{3'd2, 24'h0000F0, 9'd32,  16'd16, 8'd0,   2'd1, 8'd0},   // crosses page
    '{3'd2, 24'h000000, 9'd0,   16'd16, 8'd0,   2'd1, 8'd0},   // zero length
    '{3'd2, 24'h000000, 9'd257, 16'd16, 8'd0,   2'd1, 8'd0},   // too long
    '{3'd2, 24'h0001F0, 9'd16,  16'd16, 8'd2,   2'd0, 8'd5},   // ends on page end
    '{3'd4, 24'h000000, 9'd0,   16'd16, 8'd1,   2'd0, 8'd5},   // unprotect
    '{3'd1, 24'h020000, 9'd0,   16'd8,  8'd200, 2'd2, 8'd10},  // timeout
    '{3'd3, 24'h0001F0, 9'd16,  16'd16, 8'd0,   2'd0, 8'd1},   // read page end
    '{3'd5, 24'h000000, 9'd0,   16'd16, 8'd0,   2'd0, 8'd1},   // sleep
    '{3'd7, 24'h000000, 9'd0,   16'd16, 8'd0,   2'd1, 8'd0}    // bad op
  };

  logic got_err, got_cs, got_rst, done_after;
  logic [1:0] got_code;
  bit busy_seen;

  task automatic run_op(input logic [2:0] op, input logic [23:0] addr, input logic [8:0] len,
                        input logic [15:0] pmax, input int busy_n);
    int n;
    @(negedge clk);
    op_code = op; op_addr = addr; op_len = len; poll_max = pmax;
    busy_left = busy_n; fcnt = 0; wcnt = 0; rcnt = 0; busy_seen = 0;
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      if (busy) busy_seen = 1;
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk("R12 done never seen", 32'd0, 32'd1);
    got_err = err; got_code = err_code; got_cs = flash_cs_n; got_rst = fpga_rst_n;
    @(negedge clk);
    done_after = done;
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", flash_cs_n, 1);
    chk("R1 reset fpga_rst_n", fpga_rst_n, 1);
    chk("R1 reset busy/done/err", {busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {flash_cs_n, fpga_rst_n, busy}, 3'b110);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      run_op(v.op, v.addr, v.len, v.pmax, int'(v.busy_n));
      chk($sformatf("R7 R9 R10 err_code vec%0d", i), got_code, v.ecode);
      chk($sformatf("R12 err flag vec%0d", i), got_err, v.ecode != 0);
      chk($sformatf("R6 frame count vec%0d", i), fcnt, v.frames);
      chk($sformatf("R12 done one cycle vec%0d", i), done_after, 0);
      chk($sformatf("R12 err held vec%0d", i), {err, err_code}, {got_err, got_code});
      if (v.ecode == 2'd1)
        chk($sformatf("R9 no busy on reject vec%0d", i), busy_seen, 0);
      else if (v.op == 3'd5)
        chk("R11 both lines released", {got_cs, got_rst}, 2'b11);
      else
        chk($sformatf("R2 end lines vec%0d", i), {got_cs, got_rst}, 2'b10);
      if (i == 0) begin
        chk("R3 long reset frame", {bits_log[0], op_log[0]}, {4'd8, 8'hFF});
        chk("R3 short reset frame", {bits_log[1], op_log[1]}, {4'd2, 8'hFF});
        chk("R3 wake opcode", op_log[2], 8'hAB);
      end
      if (i == 1) begin
        chk("R5 write enable first", op_log[0], 8'h06);
        chk("R4 erase opcode", op_log[1], 8'hD8);
        chk("R4 address MSB first", {abuf[0], abuf[1], abuf[2]}, 24'h012345);
        chk("R6 poll opcodes", {op_log[2], op_log[3], op_log[4], op_log[5]}, 32'h05050505);
      end
      if (i == 2) begin
        chk("R5 write enable before program", {op_log[0], op_log[1]}, 16'h0602);
        chk("R8 bytes pulled", wcnt, 16);
      end
      if (i == 3 || i == 10) begin
        chk($sformatf("R8 bytes read vec%0d", i), rcnt, 16);
        for (int k = 0; k < 16; k++)
          chk($sformatf("R8 read data %0d vec%0d", k, i), rd_buf[k], 8'hA0 ^ k[7:0]);
        chk("R4 read opcode", op_log[0], 8'h03);
      end
      if (i == 8)
        chk("R10 unprotect frames", {op_log[0], op_log[1], op_log[2], op_log[4]}, 32'h06010505);
      if (i == 9)
        chk("R7 last frame is poll", op_log[9], 8'h05);
      if (i == 11)
        chk("R11 power-down opcode", op_log[0], 8'hB9);
    end

    // R10: status bits that refuse to clear
    stuck = 8'h1C;
    run_op(3'd4, 24'h0, 9'd0, 16'd16, 0);
    chk("R10 protect readback error", {got_err, got_code}, {1'b1, 2'd3});
    chk("R10 frames", fcnt, 4);
    stuck = 8'h00;

    // R1: reset in the middle of an operation
    @(negedge clk);
    op_code = 3'd1; op_addr = 24'h0; poll_max = 16'd1000; busy_left = 1000;
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R1 busy before abort", busy, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 abort lines", {flash_cs_n, fpga_rst_n}, 2'b11);
    chk("R1 abort flags", {busy, done, err}, 3'b000);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    chk("R2 cs low outside reset", cs_viol, 0);
    chk("R4 transfer outside frame", spi_viol, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule